// File: doc/BRIEF.md
# Operand Bypass and Interlock Controller

This block is the hazard-control logic for an in-order integer pipeline with fetch, decode, execute, memory and writeback stages. Each cycle it compares the register numbers held in the pipeline registers and drives three kinds of output:

- Select codes for the two operand multiplexers at the execute inputs.
- A hold signal that freezes the program counter and the fetch/decode register.
- Signals that kill younger instructions.

The controller holds no state of its own. Every output is a function of the current cycle's pipeline-register contents, and it is forced to its idle value while reset is asserted.

The datapath uses the outputs at the next clock edge:

- When `hold_front` is high, the PC and the fetch/decode register keep their contents.
- When `kill_idex` is high, the decode/execute register loads a no-op instead of the decoded instruction.
- When `kill_ifid` is high, the fetch/decode register is cleared.

A taken branch is resolved in execute and costs two slots. A load whose result is needed by the very next instruction costs one held cycle. All other read-after-write dependencies are covered by bypassing, so they cost nothing.

Top module: `hz_ctrl`

## Requirements
- R1: Each operand select (`byp_a_sel` for `ex_rs1`, `byp_b_sel` for `ex_rs2`) is 0 to take the register-file value. It is 1 when the execute/memory entry writes that source register, and 2 when only the memory/writeback entry writes it.
- R2: When both the execute/memory and the memory/writeback entries write the same source register, the select is 1, because the younger entry wins.
- R3: An entry whose write enable is low, or whose destination is register 0, never causes a select of 1 or 2.
- R4: A load-use hazard exists when all of the following hold:
  - the execute-stage instruction is a load, has its write enable set and has a nonzero destination;
  - that destination equals a decode-stage source register that is marked as used.
  
  With no taken branch, a load-use hazard drives `hold_front`=1, `kill_idex`=1 and `kill_ifid`=0.
- R5: A decode-stage source register whose use flag is low never causes a hold, even if it matches the destination of a load.
- R6: When the execute-stage instruction is not a load, a matching decode source causes no hold.
- R7: When `br_taken` is high, `kill_ifid`=1, `kill_idex`=1 and `hold_front`=0.
- R8: A taken branch overrides a load-use hazard in the same cycle, so `hold_front` stays 0.
- R9: Neither select output is ever 3.
- R10: While `rst_n` is low, both selects are 0 and `hold_front`, `kill_idex` and `kill_ifid` are 0, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used by the assertions only |
| rst_n | input | 1 | Active-low reset; forces every output idle |
| id_rs1 | input | REG_AW | Decode-stage first source register |
| id_rs2 | input | REG_AW | Decode-stage second source register |
| id_use1 | input | 1 | Decode-stage first source is read |
| id_use2 | input | 1 | Decode-stage second source is read |
| ex_rs1 | input | REG_AW | Execute-stage first source register |
| ex_rs2 | input | REG_AW | Execute-stage second source register |
| ex_rd | input | REG_AW | Execute-stage destination register |
| ex_wen | input | 1 | Execute-stage register write enable |
| ex_load | input | 1 | Execute-stage instruction is a load |
| br_taken | input | 1 | Branch in execute resolved taken |
| mem_rd | input | REG_AW | Execute/memory register destination |
| mem_wen | input | 1 | Execute/memory register write enable |
| wb_rd | input | REG_AW | Memory/writeback register destination |
| wb_wen | input | 1 | Memory/writeback register write enable |
| byp_a_sel | output | 2 | Select for the first execute operand |
| byp_b_sel | output | 2 | Select for the second execute operand |
| hold_front | output | 1 | Freeze the PC and the fetch/decode register |
| kill_idex | output | 1 | Load a no-op into the decode/execute register |
| kill_ifid | output | 1 | Clear the fetch/decode register |

## Verification
The assertions are checked on every cycle. They cover the following:
- a select is never 3;
- a nonzero select always traces back to an enabled, nonzero, matching destination;
- a select of 2 never appears while the younger entry also matches;
- a hold always comes with a no-op in execute;
- a taken branch always kills both younger slots and never holds.

The directed scenarios are needed for the following:
- the exact select value chosen in each overlap case;
- that an unused source or a non-load producer causes no hold;
- that the outputs stay idle during reset.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    SEL_RF  = 2'd0,
    SEL_MEM = 2'd1,
    SEL_WB  = 2'd2
  } byp_sel_e;
endpackage

// File: rtl/hz_bypass.sv
module hz_bypass #(
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] src,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic              mem_wen,
  input  logic [REG_AW-1:0] wb_rd,
  input  logic              wb_wen,
  output logic [1:0]        sel
);
  import hz_pkg::*;
  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic mem_hit, wb_hit;
  byp_sel_e sel_e;

  assign mem_hit = mem_wen && (mem_rd != ZERO_REG) && (mem_rd == src);
  assign wb_hit  = wb_wen  && (wb_rd  != ZERO_REG) && (wb_rd  == src);

  // younger entry checked first
  always_comb begin
    if (mem_hit)     sel_e = SEL_MEM;
    else if (wb_hit) sel_e = SEL_WB;
    else             sel_e = SEL_RF;
  end

  assign sel = rst_n ? sel_e : 2'd0;

  // R9
  sel_not_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel != 2'd3);
  // R3
  sel_mem_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'd1) |-> (mem_wen && mem_rd != 0 && mem_rd == src));
  // R2
  sel_wb_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'd2) |-> (wb_wen && wb_rd != 0 && wb_rd == src &&
                       !(mem_wen && mem_rd != 0 && mem_rd == src)));
endmodule

// File: rtl/hz_loaduse.sv
module hz_loaduse #(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] ex_rd,
  input  logic              ex_wen,
  input  logic              ex_load,
  input  logic [REG_AW-1:0] id_rs1,
  input  logic [REG_AW-1:0] id_rs2,
  input  logic              id_use1,
  input  logic              id_use2,
  output logic              hazard
);
  localparam logic [REG_AW-1:0] ZERO_REG = '0;
  logic producer, hit1, hit2;

  assign producer = ex_load && ex_wen && (ex_rd != ZERO_REG);
  assign hit1     = id_use1 && (id_rs1 == ex_rd);
  assign hit2     = id_use2 && (id_rs2 == ex_rd);
  assign hazard   = producer && (hit1 || hit2);
endmodule

// File: rtl/hz_steer.sv
module hz_steer (
  input  logic clk,
  input  logic rst_n,
  input  logic lu_hazard,
  input  logic br_taken,
  output logic hold_front,
  output logic kill_idex,
  output logic kill_ifid
);
  logic hold_raw, kill_id_raw, kill_if_raw;

  // branch redirect wins: a slot about to be killed must not hold
  assign hold_raw    = lu_hazard && !br_taken;
  assign kill_id_raw = hold_raw || br_taken;
  assign kill_if_raw = br_taken;

  assign hold_front = rst_n && hold_raw;
  assign kill_idex  = rst_n && kill_id_raw;
  assign kill_ifid  = rst_n && kill_if_raw;

  // R4
  hold_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_front |-> (kill_idex && !kill_ifid));
  // R8
  redirect_no_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |-> !hold_front);
endmodule

// File: rtl/hz_ctrl.sv
module hz_ctrl #(
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] id_rs1,
  input  logic [REG_AW-1:0] id_rs2,
  input  logic              id_use1,
  input  logic              id_use2,
  input  logic [REG_AW-1:0] ex_rs1,
  input  logic [REG_AW-1:0] ex_rs2,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic              ex_wen,
  input  logic              ex_load,
  input  logic              br_taken,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic              mem_wen,
  input  logic [REG_AW-1:0] wb_rd,
  input  logic              wb_wen,
  output logic [1:0]        byp_a_sel,
  output logic [1:0]        byp_b_sel,
  output logic              hold_front,
  output logic              kill_idex,
  output logic              kill_ifid
);
  localparam int N_OPS = 2;

  logic [REG_AW-1:0] ops_src [N_OPS];
  logic [1:0]        ops_sel [N_OPS];
  logic              lu_hazard;

  assign ops_src[0] = ex_rs1;
  assign ops_src[1] = ex_rs2;

  for (genvar g = 0; g < N_OPS; g++) begin : g_op
    hz_bypass #(.REG_AW(REG_AW)) u_byp (
      .clk    (clk),
      .rst_n  (rst_n),
      .src    (ops_src[g]),
      .mem_rd (mem_rd),
      .mem_wen(mem_wen),
      .wb_rd  (wb_rd),
      .wb_wen (wb_wen),
      .sel    (ops_sel[g])
    );
  end

  assign byp_a_sel = ops_sel[0];
  assign byp_b_sel = ops_sel[1];

  hz_loaduse #(.REG_AW(REG_AW)) u_lu (
    .ex_rd  (ex_rd),
    .ex_wen (ex_wen),
    .ex_load(ex_load),
    .id_rs1 (id_rs1),
    .id_rs2 (id_rs2),
    .id_use1(id_use1),
    .id_use2(id_use2),
    .hazard (lu_hazard)
  );

  hz_steer u_steer (
    .clk       (clk),
    .rst_n     (rst_n),
    .lu_hazard (lu_hazard),
    .br_taken  (br_taken),
    .hold_front(hold_front),
    .kill_idex (kill_idex),
    .kill_ifid (kill_ifid)
  );

  // R7
  redirect_kills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |-> (kill_ifid && kill_idex));
  // R6
  nonload_no_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_load |-> !hold_front);
endmodule

// File: tb/hz_ctrl_tb.sv
module hz_ctrl_tb;
  localparam int AW = 5;
  logic clk = 0, rst_n = 0;
  logic [AW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
  logic id_use1, id_use2, ex_wen, ex_load, br_taken, mem_wen, wb_wen;
  logic [1:0] byp_a_sel, byp_b_sel;
  logic hold_front, kill_idex, kill_ifid;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  hz_ctrl #(.REG_AW(AW)) u_dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    {id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd} = '0;
    {id_use1, id_use2, ex_wen, ex_load, br_taken, mem_wen, wb_wen} = '0;
  endtask

  task automatic settle(); #3; endtask

  task automatic t_reset();
    idle();
    ex_rs1 = 5'd3; mem_rd = 5'd3; mem_wen = 1; br_taken = 1;
    ex_load = 1; ex_wen = 1; ex_rd = 5'd4; id_rs1 = 5'd4; id_use1 = 1;
    settle();
    chk("R10 sel_a", byp_a_sel, 0);
    chk("R10 hold", hold_front, 0);
    chk("R10 kill_idex", kill_idex, 0);
    chk("R10 kill_ifid", kill_ifid, 0);
  endtask

  task automatic t_codes();
    idle(); settle();
    chk("R1 idle sel_a", byp_a_sel, 0);
    chk("R1 idle hold", hold_front, 0);
    idle();
    ex_rs1 = 5'd7; ex_rs2 = 5'd9; mem_rd = 5'd7; mem_wen = 1;
    wb_rd = 5'd9; wb_wen = 1; settle();
    chk("R1 sel_a mem", byp_a_sel, 1);
    chk("R1 sel_b wb", byp_b_sel, 2);
    idle();
    ex_rs1 = 5'd5; ex_rs2 = 5'd6; mem_rd = 5'd6; mem_wen = 1; settle();
    chk("R1 sel_a rf", byp_a_sel, 0);
    chk("R1 sel_b mem", byp_b_sel, 1);
  endtask

  task automatic t_younger();
    idle();
    ex_rs1 = 5'd12; ex_rs2 = 5'd12; mem_rd = 5'd12; mem_wen = 1;
    wb_rd = 5'd12; wb_wen = 1; settle();
    chk("R2 sel_a", byp_a_sel, 1);
    chk("R2 sel_b", byp_b_sel, 1);
    chk("R9 sel_a not 3", int'(byp_a_sel == 2'd3), 0);
  endtask

  task automatic t_no_fwd();
    idle();
    ex_rs1 = 5'd0; ex_rs2 = 5'd0; mem_rd = 5'd0; mem_wen = 1;
    wb_rd = 5'd0; wb_wen = 1; settle();
    chk("R3 reg0 a", byp_a_sel, 0);
    chk("R3 reg0 b", byp_b_sel, 0);
    idle();
    ex_rs1 = 5'd8; ex_rs2 = 5'd8; mem_rd = 5'd8; wb_rd = 5'd8; settle();
    chk("R3 wen low a", byp_a_sel, 0);
    idle();
    ex_rs1 = 5'd8; mem_rd = 5'd8; wb_rd = 5'd8; wb_wen = 1; settle();
    chk("R3 mem wen low falls to wb", byp_a_sel, 2);
  endtask

  task automatic t_loaduse();
    idle();
    ex_load = 1; ex_wen = 1; ex_rd = 5'd10; id_rs2 = 5'd10; id_use2 = 1;
    settle();
    chk("R4 hold", hold_front, 1);
    chk("R4 kill_idex", kill_idex, 1);
    chk("R4 kill_ifid", kill_ifid, 0);
    idle();
    ex_load = 1; ex_wen = 1; ex_rd = 5'd0; id_rs1 = 5'd0; id_use1 = 1;
    settle();
    chk("R4 reg0 load no hold", hold_front, 0);
  endtask

  task automatic t_unused();
    idle();
    ex_load = 1; ex_wen = 1; ex_rd = 5'd11; id_rs1 = 5'd11; id_rs2 = 5'd11;
    settle();
    chk("R5 unused hold", hold_front, 0);
    chk("R5 unused kill_idex", kill_idex, 0);
  endtask

  task automatic t_alu_raw();
    idle();
    ex_wen = 1; ex_rd = 5'd13; id_rs1 = 5'd13; id_use1 = 1; settle();
    chk("R6 alu no hold", hold_front, 0);
    chk("R6 alu no bubble", kill_idex, 0);
  endtask

  task automatic t_branch();
    idle();
    br_taken = 1; settle();
    chk("R7 kill_ifid", kill_ifid, 1);
    chk("R7 kill_idex", kill_idex, 1);
    chk("R7 hold", hold_front, 0);
    idle();
    br_taken = 1; ex_load = 1; ex_wen = 1; ex_rd = 5'd14;
    id_rs1 = 5'd14; id_use1 = 1; settle();
    chk("R8 hold suppressed", hold_front, 0);
    chk("R8 kill_ifid", kill_ifid, 1);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    @(negedge clk); rst_n = 1;
    t_codes();
    t_younger();
    t_no_fwd();
    t_loaduse();
    t_unused();
    t_alu_raw();
    t_branch();
    idle();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule